// File: doc/BRIEF.md
# Interrupt Vector Priority Selector

This block gathers interrupt requests from a small microcontroller's peripherals. It decides which one the CPU should service next, and it supplies the byte address of the 16-bit vector word that holds that handler's start address. The vector table has sixteen word slots at the top of the address space. Slot *n* sits at address 0xFFE0 + 2·*n*, and a higher slot number means higher priority. Several peripheral flags may share one slot.

Each source belongs to one of three gating classes:

- **Maskable.** The source needs both its own enable bit and the global enable.
- **Enable-only.** The fault group at slot 14 obeys its per-flag enable and ignores the global enable.
- **Unconditional.** The reset cause, at slot 15, obeys neither enable.

The CPU sees a single request line and reads the vector address. It then strobes `ack`. In the next cycle the block answers with a one-cycle one-hot grant to the winning slot group, so that the peripheral can clear its own flag. The acknowledge also blocks maskable arbitration until software drops the global enable and raises it again. While a request is outstanding, the chosen vector is held steady. A reset cause is the one exception: it always takes over at once.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, with all flags low, `irq` is 0, `vec_addr` is 0x0000 and `grant` is all zeros. Whenever `irq` is 0, `vec_addr` reads 0x0000.
- R2: When a request is shown, `vec_addr` equals 0xFFE0 + 2·slot. The slots are: reset 15, fault group 14, comparator 11, watchdog interval 10, timer channel 0 is 9, other timer flags 8, port 2 is 3, port 1 is 2.
- R3: A high `rst_cause` forces `irq`=1 and `vec_addr`=0xFFFE in the same cycle. No enable can prevent this, and it overrides any held or pending selection.
- R4: Any of the three fault flags (`nmi_flags[2:0]`) whose matching `nmi_en` bit is high raises slot 14 (0xFFFC), even with `gie` low. A fault flag whose enable bit is low raises nothing.
- R5: A maskable source requests only when its flag, its own enable bit and `gie` are all high. Clearing either enable removes the request.
- R6: When several qualified slots compete and nothing is held, the highest slot number wins.
- R7: Port 2 flag bits outside the pin mask have no effect, whatever their enable. The default mask is 0x3F, so bits 7 and 6 are ignored.
- R8: Slots 13, 12, 7, 6, 5, 4, 1 and 0 are never presented.
- R9: Once a slot has been presented for one clock edge without `ack`, it stays presented while it remains qualified, even if a higher maskable or fault slot arrives. When it stops qualifying, the selection re-arbitrates immediately.
- R10: If `ack` is high in a cycle where `irq` is high, `grant` shows, for exactly the following cycle, a one-hot bit at the slot that was presented. In every other case `grant` is zero.
- R11: After an accepted `ack`, maskable sources are blocked even while `gie` stays high. The block clears in the first cycle that `gie` is low. Slot 14 and slot 15 are unaffected by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_cause | input | 1 | Reset or power-up cause, unconditional |
| nmi_flags | input | 3 | Fault group flags (pin event, oscillator fault, flash violation) |
| nmi_en | input | 3 | Per-flag enables of the fault group |
| cmp_flag | input | 1 | Comparator flag |
| cmp_en | input | 1 | Comparator enable |
| wdt_flag | input | 1 | Watchdog interval flag |
| wdt_en | input | 1 | Watchdog interval enable |
| tmr0_flag | input | 1 | Timer channel 0 flag |
| tmr0_en | input | 1 | Timer channel 0 enable |
| tmr_flags | input | 3 | Remaining timer flags (channels 1, 2, overflow) |
| tmr_en | input | 3 | Enables of the remaining timer flags |
| p2_flags | input | 8 | Port 2 flags |
| p2_en | input | 8 | Port 2 enables |
| p1_flags | input | 8 | Port 1 flags |
| p1_en | input | 8 | Port 1 enables |
| gie | input | 1 | Global enable for maskable sources |
| ack | input | 1 | CPU acknowledge strobe |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Byte address of the selected vector word |
| grant | output | 16 | One-cycle one-hot grant, indexed by slot |

## Verification
Each source is raised alone, with every combination of its own enable and the global enable. This separates the three gating classes from each other and confirms each slot's address. Pairs of sources are then raised in the same cycle and in staggered cycles. Simultaneous arrival exercises pure priority. Staggered arrival shows that the hold rule outranks priority, and that the reset cause breaks the hold. Port 2 is driven with only its unmapped bits set, to show that they are ignored. An acknowledge is issued both with and without a pending request, which separates a real grant from a spurious one. A `gie` drop and re-raise after the acknowledge shows that the block clears only through that sequence.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants of the interrupt vector selector.
// Assumes a 16-slot table of 16-bit words at the top of a 16-bit byte space.
package irq_arb_pkg;
    localparam int VEC_W     = 16;
    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFE0;

    // Slot numbers (a higher number means a higher priority).
    localparam int SLOT_RST  = 15;
    localparam int SLOT_NMI  = 14;
    localparam int SLOT_CMP  = 11;
    localparam int SLOT_WDT  = 10;
    localparam int SLOT_TMR0 = 9;
    localparam int SLOT_TMRX = 8;
    localparam int SLOT_P2   = 3;
    localparam int SLOT_P1   = 2;

    // Bit map of the slots that have a source attached.
    localparam logic [NUM_SLOTS-1:0] USED_SLOTS =
        (NUM_SLOTS'(1) << SLOT_RST)  | (NUM_SLOTS'(1) << SLOT_NMI)  |
        (NUM_SLOTS'(1) << SLOT_CMP)  | (NUM_SLOTS'(1) << SLOT_WDT)  |
        (NUM_SLOTS'(1) << SLOT_TMR0) | (NUM_SLOTS'(1) << SLOT_TMRX) |
        (NUM_SLOTS'(1) << SLOT_P2)   | (NUM_SLOTS'(1) << SLOT_P1);

    // Byte address of a slot's vector word.
    function automatic logic [VEC_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
        return VEC_BASE + VEC_W'({s, 1'b0});
    endfunction
endpackage

// File: rtl/irq_qualify.sv
// Module: applies the gating class of every source and folds flags into slots.
// Assumes gie_eff already includes the post-acknowledge block; unused slots are tied low.
module irq_qualify
    import irq_arb_pkg::*;
#(
    parameter int          NMI_N       = 3,
    parameter int          TMR_N       = 3,
    parameter int          PORT_W      = 8,
    parameter logic [7:0]  P2_PIN_MASK = 8'h3F
) (
    input  logic                 rst_cause,
    input  logic [NMI_N-1:0]     nmi_flags,
    input  logic [NMI_N-1:0]     nmi_en,
    input  logic                 cmp_flag,
    input  logic                 cmp_en,
    input  logic                 wdt_flag,
    input  logic                 wdt_en,
    input  logic                 tmr0_flag,
    input  logic                 tmr0_en,
    input  logic [TMR_N-1:0]     tmr_flags,
    input  logic [TMR_N-1:0]     tmr_en,
    input  logic [PORT_W-1:0]    p2_flags,
    input  logic [PORT_W-1:0]    p2_en,
    input  logic [PORT_W-1:0]    p1_flags,
    input  logic [PORT_W-1:0]    p1_en,
    input  logic                 gie_eff,
    output logic [NUM_SLOTS-1:0] qual
);
    logic [PORT_W-1:0] p2_hits;

    // Port 2 bits outside the pin mask can never qualify.
    for (genvar i = 0; i < PORT_W; i++) begin : g_p2
        if (P2_PIN_MASK[i]) begin : g_pin
            assign p2_hits[i] = p2_flags[i] & p2_en[i];
        end else begin : g_nopin
            assign p2_hits[i] = 1'b0;
        end
    end

    // Build the per-slot qualified vector according to each slot's gating class.
    always_comb begin
        qual            = '0;
        qual[SLOT_RST]  = rst_cause;
        qual[SLOT_NMI]  = |(nmi_flags & nmi_en);
        qual[SLOT_CMP]  = gie_eff & cmp_flag & cmp_en;
        qual[SLOT_WDT]  = gie_eff & wdt_flag & wdt_en;
        qual[SLOT_TMR0] = gie_eff & tmr0_flag & tmr0_en;
        qual[SLOT_TMRX] = gie_eff & (|(tmr_flags & tmr_en));
        qual[SLOT_P2]   = gie_eff & (|p2_hits);
        qual[SLOT_P1]   = gie_eff & (|(p1_flags & p1_en));
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, the highest set bit wins.
// Assumes N is a power of two no larger than the slot index range.
module irq_prio_pick #(
    parameter int N   = 16,
    parameter int IDX = $clog2(N)
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IDX-1:0] idx
);
    // Scan upward so that the last (highest) set bit remains.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
// Module: top of the interrupt vector selector.
// It holds the presented slot while that slot stays qualified, lets the reset cause
// override everything, pulses a grant after an acknowledge and blocks maskable
// sources after that acknowledge until gie goes low.
// Assumes ack is a single-cycle strobe, synchronous to clk.
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int         NMI_N       = 3,
    parameter int         TMR_N       = 3,
    parameter int         PORT_W      = 8,
    parameter logic [7:0] P2_PIN_MASK = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_cause,
    input  logic [NMI_N-1:0]     nmi_flags,
    input  logic [NMI_N-1:0]     nmi_en,
    input  logic                 cmp_flag,
    input  logic                 cmp_en,
    input  logic                 wdt_flag,
    input  logic                 wdt_en,
    input  logic                 tmr0_flag,
    input  logic                 tmr0_en,
    input  logic [TMR_N-1:0]     tmr_flags,
    input  logic [TMR_N-1:0]     tmr_en,
    input  logic [PORT_W-1:0]    p2_flags,
    input  logic [PORT_W-1:0]    p2_en,
    input  logic [PORT_W-1:0]    p1_flags,
    input  logic [PORT_W-1:0]    p1_en,
    input  logic                 gie,
    input  logic                 ack,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec_addr,
    output logic [NUM_SLOTS-1:0] grant
);
    logic [NUM_SLOTS-1:0] qual;
    logic                 any_q;
    logic [SLOT_W-1:0]    best_slot;
    logic [SLOT_W-1:0]    shown_slot;
    logic [SLOT_W-1:0]    held_slot;
    logic                 held_valid;
    logic                 gie_blk;
    logic                 gie_eff;
    logic                 take;

    assign gie_eff = gie & ~gie_blk;

    irq_qualify #(
        .NMI_N(NMI_N), .TMR_N(TMR_N), .PORT_W(PORT_W), .P2_PIN_MASK(P2_PIN_MASK)
    ) u_qual (
        .rst_cause(rst_cause), .nmi_flags(nmi_flags), .nmi_en(nmi_en),
        .cmp_flag(cmp_flag), .cmp_en(cmp_en), .wdt_flag(wdt_flag), .wdt_en(wdt_en),
        .tmr0_flag(tmr0_flag), .tmr0_en(tmr0_en), .tmr_flags(tmr_flags), .tmr_en(tmr_en),
        .p2_flags(p2_flags), .p2_en(p2_en), .p1_flags(p1_flags), .p1_en(p1_en),
        .gie_eff(gie_eff), .qual(qual)
    );

    irq_prio_pick #(.N(NUM_SLOTS)) u_pick (
        .req(qual), .any(any_q), .idx(best_slot)
    );

    // Choose the slot to present: the reset cause first, then a still-valid held slot, then priority.
    always_comb begin
        if (rst_cause)
            shown_slot = SLOT_W'(SLOT_RST);
        else if (held_valid && qual[held_slot])
            shown_slot = held_slot;
        else
            shown_slot = best_slot;
    end

    assign irq      = any_q;
    assign vec_addr = any_q ? slot_addr(shown_slot) : '0;
    assign take     = ack & any_q;

    // Remember the presented slot across cycles; an accepted acknowledge releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
            held_slot  <= '0;
        end else if (!any_q || take) begin
            held_valid <= 1'b0;
        end else begin
            held_valid <= 1'b1;
            held_slot  <= shown_slot;
        end
    end

    // Register a one-cycle grant to the slot presented when the acknowledge arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant <= '0;
        else
            grant <= take ? (NUM_SLOTS'(1) << shown_slot) : '0;
    end

    // Block maskable sources after an accepted acknowledge until gie is seen low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_blk <= 1'b0;
        else if (take)
            gie_blk <= 1'b1;
        else if (!gie)
            gie_blk <= 1'b0;
    end
endmodule

// File: rtl/irq_arb_checker.sv
// Checker: temporal properties of the vector selector's ports, attached by bind.
// Assumes the default slot map from irq_arb_pkg.
module irq_arb_checker
    import irq_arb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rst_cause,
    input logic                 ack,
    input logic                 irq,
    input logic [VEC_W-1:0]     vec_addr,
    input logic [NUM_SLOTS-1:0] grant
);
    // R1: no request means a zero address.
    a_r1_idle_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> vec_addr == '0);

    // R3: the reset cause always wins.
    a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cause |-> (irq && vec_addr == 16'hFFFE));

    // R8: only populated slots inside the table are presented.
    a_r8_used_slot: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_addr[VEC_W-1:5] == '1 && vec_addr[0] == 1'b0
                 && USED_SLOTS[vec_addr[4:1]]));

    // R10: the grant is never more than one-hot.
    a_r10_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: an accepted acknowledge yields the grant of the presented slot.
    a_r10_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> grant == (NUM_SLOTS'(1) << $past(vec_addr[4:1])));

    // R10: no grant without an accepted acknowledge.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq) |=> grant == '0);
endmodule

bind irq_vector_arbiter irq_arb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .ack(ack),
    .irq(irq), .vec_addr(vec_addr), .grant(grant)
);

// File: tb/tb_irq_vector_arbiter.sv
module tb_irq_vector_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_cause;
    logic [2:0]  nmi_flags, nmi_en;
    logic        cmp_flag, cmp_en, wdt_flag, wdt_en, tmr0_flag, tmr0_en;
    logic [2:0]  tmr_flags, tmr_en;
    logic [7:0]  p2_flags, p2_en, p1_flags, p1_en;
    logic        gie, ack;
    logic        irq;
    logic [15:0] vec_addr;
    logic [15:0] grant;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_vector_arbiter dut (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause),
        .nmi_flags(nmi_flags), .nmi_en(nmi_en),
        .cmp_flag(cmp_flag), .cmp_en(cmp_en), .wdt_flag(wdt_flag), .wdt_en(wdt_en),
        .tmr0_flag(tmr0_flag), .tmr0_en(tmr0_en), .tmr_flags(tmr_flags), .tmr_en(tmr_en),
        .p2_flags(p2_flags), .p2_en(p2_en), .p1_flags(p1_flags), .p1_en(p1_en),
        .gie(gie), .ack(ack), .irq(irq), .vec_addr(vec_addr), .grant(grant)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the request line and the address together.
    task automatic expect_out(input string req, input logic e_irq, input logic [15:0] e_vec);
        chk(irq === e_irq, req, {31'd0, irq}, {31'd0, e_irq});
        chk(vec_addr === e_vec, req, {16'd0, vec_addr}, {16'd0, e_vec});
    endtask

    // Go to just after the next falling edge; then drive inputs and let them settle.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rst_cause = 0; nmi_flags = 0; nmi_en = 0;
        cmp_flag = 0; cmp_en = 0; wdt_flag = 0; wdt_en = 0;
        tmr0_flag = 0; tmr0_en = 0; tmr_flags = 0; tmr_en = 0;
        p2_flags = 0; p2_en = 0; p1_flags = 0; p1_en = 0;
        gie = 0; ack = 0;
    endtask

    // Clean slate between scenarios: drop all inputs and let held state empty.
    task automatic settle();
        step(); idle_inputs(); #1;
        step(); step(); #1;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step(); #1;
        expect_out("R1 reset", 1'b0, 16'h0000);
        chk(grant === 16'h0, "R1 grant", {16'd0, grant}, 32'd0);
    endtask

    // Each maskable source alone under every enable combination.
    task automatic t_maskable();
        for (int s = 0; s < 6; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [15:0] a;
                settle();
                gie = c[1];
                case (s)
                    0: begin cmp_flag = 1;  cmp_en = c[0];  a = 16'hFFF6; end
                    1: begin wdt_flag = 1;  wdt_en = c[0];  a = 16'hFFF4; end
                    2: begin tmr0_flag = 1; tmr0_en = c[0]; a = 16'hFFF2; end
                    3: begin tmr_flags = 3'b100; tmr_en = {c[0], 2'b11}; a = 16'hFFF0; end
                    4: begin p2_flags = 8'h20; p2_en = {2'b11, c[0], 5'h1F}; a = 16'hFFE6; end
                    default: begin p1_flags = 8'h81; p1_en = {c[0], 6'h0, 1'b0}; a = 16'hFFE4; end
                endcase
                #1;
                if (c == 3) expect_out("R5 R2 maskable qualified", 1'b1, a);
                else        expect_out("R5 maskable gated", 1'b0, 16'h0000);
            end
        end
    endtask

    task automatic t_nmi();
        for (int b = 0; b < 3; b++) begin
            settle();
            nmi_flags = 3'b001 << b; nmi_en = 3'b001 << b; gie = 0; #1;
            expect_out("R4 fault flag ignores gie", 1'b1, 16'hFFFC);
            nmi_en = ~(3'b001 << b); #1;
            expect_out("R4 fault flag own enable", 1'b0, 16'h0000);
        end
    endtask

    task automatic t_reset_cause();
        settle();
        p1_flags = 8'h01; p1_en = 8'h01; gie = 1; #1;
        expect_out("R3 setup", 1'b1, 16'hFFE4);
        step(); #1;   // port 1 is now held
        rst_cause = 1; #1;
        expect_out("R3 overrides hold", 1'b1, 16'hFFFE);
        settle();
        rst_cause = 1; #1;
        expect_out("R3 no enables", 1'b1, 16'hFFFE);
    endtask

    task automatic t_priority();
        settle();
        gie = 1;
        p1_flags = 1; p1_en = 1; p2_flags = 1; p2_en = 1;
        tmr_flags = 1; tmr_en = 1; wdt_flag = 1; wdt_en = 1; #1;
        expect_out("R6 watchdog wins", 1'b1, 16'hFFF4);
        settle();
        gie = 1; p1_flags = 1; p1_en = 1; nmi_flags = 3'b010; nmi_en = 3'b010;
        cmp_flag = 1; cmp_en = 1; #1;
        expect_out("R6 fault group wins", 1'b1, 16'hFFFC);
    endtask

    task automatic t_port2_mask();
        settle();
        gie = 1; p2_flags = 8'hC0; p2_en = 8'hFF; #1;
        expect_out("R7 unmapped port 2 bits", 1'b0, 16'h0000);
        p2_flags = 8'hC1; #1;
        expect_out("R7 mapped port 2 bit", 1'b1, 16'hFFE6);
    endtask

    task automatic t_unused();
        settle();
        gie = 1; nmi_flags = 3'b111; nmi_en = 3'b111; cmp_flag = 1; cmp_en = 1; #1;
        chk(vec_addr !== 16'hFFFA && vec_addr !== 16'hFFF8, "R8 empty slot",
            {16'd0, vec_addr}, 32'h0000FFFC);
    endtask

    task automatic t_hold();
        settle();
        gie = 1; p1_flags = 1; p1_en = 1; #1;
        step(); #1;
        cmp_flag = 1; cmp_en = 1; #1;
        expect_out("R9 hold against comparator", 1'b1, 16'hFFE4);
        step(); #1;
        nmi_flags = 1; nmi_en = 1; #1;
        expect_out("R9 hold against fault group", 1'b1, 16'hFFE4);
        p1_flags = 0; #1;
        expect_out("R9 rearbitrate on release", 1'b1, 16'hFFFC);
    endtask

    task automatic t_ack();
        settle();
        ack = 1; #1;
        step(); #1;
        chk(grant === 16'h0, "R10 ack without request", {16'd0, grant}, 32'd0);
        ack = 0;
        gie = 1; tmr0_flag = 1; tmr0_en = 1; ack = 1; #1;
        step(); ack = 0; #1;
        chk(grant === 16'h0200, "R10 grant slot 9", {16'd0, grant}, 32'h200);
        step(); #1;
        chk(grant === 16'h0, "R10 grant one cycle", {16'd0, grant}, 32'd0);
    endtask

    task automatic t_gie_block();
        settle();
        gie = 1; wdt_flag = 1; wdt_en = 1; #1;
        ack = 1; step(); ack = 0; #1;
        expect_out("R11 blocked after ack", 1'b0, 16'h0000);
        step(); #1;
        expect_out("R11 still blocked with gie high", 1'b0, 16'h0000);
        nmi_flags = 3'b100; nmi_en = 3'b100; #1;
        expect_out("R11 fault group unaffected", 1'b1, 16'hFFFC);
        nmi_flags = 0;
        gie = 0; step(); #1;
        gie = 1; #1;
        expect_out("R11 released by gie toggle", 1'b1, 16'hFFF4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_maskable();
        t_nmi();
        t_reset_cause();
        t_priority();
        t_port2_mask();
        t_unused();
        t_hold();
        t_ack();
        t_gie_block();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule